// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit integer core and a word-wide synchronous data memory. For each memory request it forms the effective byte address from a base register value and a signed 16-bit displacement, and decodes the opcode into an access size (byte, halfword or word), a direction (load or store) and an extension mode (sign or zero).

For stores, it places the low-order bits of the source register on every lane that the access can hit and drives the byte enables of the addressed lanes only. For loads, it pulses a read strobe, remembers the size, extension mode and lane offset for one cycle, and picks the addressed byte or halfword out of the returned word in the next cycle. It then sign-extends or zero-extends that value to 32 bits. Lanes are big-endian: byte offset 0 is the most significant byte of the memory word. A halfword at an odd address, or a word at an address that is not a multiple of four, raises a misalignment flag and the memory is not touched.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr_o` equals `rs_i` plus `imm_i` sign-extended to 32 bits, in the same cycle. With `rs_i` = 0 it is the extended displacement alone, and with `imm_i` = 0 it is `rs_i`.
- R2: Store byte enables are big-endian, with `mem_be_o[3]` covering bits 31:24 and `mem_be_o[0]` covering bits 7:0. A byte store (opcode 0x28) at offset k sets only bit 3-k. A halfword store (0x29) sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store (0x2b) sets 4'b1111.
- R3: Store write data repeats `rt_i[7:0]` on all four lanes for a byte store, and `rt_i[15:0]` in both halves for a halfword store. A word store drives `rt_i` unchanged.
- R4: A load result is taken from the lane the address offset selects. A byte at offset k comes from bits 31-8k down to 24-8k. A halfword at offset 0 comes from bits 31:16, and one at offset 2 comes from bits 15:0.
- R5: Opcodes 0x20 (byte) and 0x21 (halfword) copy the loaded value's top bit into the upper result bits. Opcodes 0x24 (byte) and 0x25 (halfword) fill them with zeros. Opcode 0x23 returns the whole word.
- R6: A halfword access at an odd address, or a word access with non-zero address bits 1:0, asserts `misalign_o` in the request cycle. It drives `mem_be_o` to zero, does not pulse `mem_rd_o` and produces no load result.
- R7: An aligned load pulses `mem_rd_o` in the request cycle. `load_valid_o` is high, with `load_data_o` valid, exactly in the following cycle.
- R8: While `req_valid_i` is low, or the opcode is none of the eight load/store codes, `mem_be_o`, `mem_rd_o` and `misalign_o` stay at zero.
- R9: After reset, `load_valid_o` is low until a load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| opcode_i | input | 6 | Instruction opcode field |
| rs_i | input | 32 | Base register value |
| rt_i | input | 32 | Store source register value |
| imm_i | input | 16 | Signed displacement |
| mem_rdata_i | input | 32 | Memory read word, one cycle after the strobe |
| mem_addr_o | output | 32 | Effective byte address |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| mem_be_o | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_rd_o | output | 1 | Read strobe |
| load_data_o | output | 32 | Extended load result |
| load_valid_o | output | 1 | Load result valid |
| misalign_o | output | 1 | Misaligned access flag |

## Verification
Most of the block is combinational, so a wrong address sum, lane decode or enable pattern shows at the ports in the request cycle itself. It appears as a wrong `mem_addr_o`, a wrong bit pattern in `mem_be_o`, or a write that reaches the wrong lane of the shadow memory. The only state is the one-cycle record of a pending load. If its size, offset or extension bit is captured wrongly, the result `load_data_o` is wrong exactly one cycle after the strobe. If its valid bit is wrong, `load_valid_o` appears without a strobe or fails to follow one. The bench's load scoreboard reports either case at that following cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_LD_B_S = 6'h20;
  localparam logic [OP_W-1:0] OPC_LD_H_S = 6'h21;
  localparam logic [OP_W-1:0] OPC_LD_W   = 6'h23;
  localparam logic [OP_W-1:0] OPC_LD_B_U = 6'h24;
  localparam logic [OP_W-1:0] OPC_LD_H_U = 6'h25;
  localparam logic [OP_W-1:0] OPC_ST_B   = 6'h28;
  localparam logic [OP_W-1:0] OPC_ST_H   = 6'h29;
  localparam logic [OP_W-1:0] OPC_ST_W   = 6'h2b;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    acc_size_e size;
    logic      sign_ext;
  } acc_ctl_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output acc_ctl_t        ctl_o
);

  always_comb begin
    ctl_o = '{is_load: 1'b0, is_store: 1'b0, size: SZ_BYTE, sign_ext: 1'b0};
    unique case (opcode_i)
      OPC_LD_B_S: ctl_o = '{is_load: 1'b1, is_store: 1'b0, size: SZ_BYTE, sign_ext: 1'b1};
      OPC_LD_H_S: ctl_o = '{is_load: 1'b1, is_store: 1'b0, size: SZ_HALF, sign_ext: 1'b1};
      OPC_LD_W:   ctl_o = '{is_load: 1'b1, is_store: 1'b0, size: SZ_WORD, sign_ext: 1'b0};
      OPC_LD_B_U: ctl_o = '{is_load: 1'b1, is_store: 1'b0, size: SZ_BYTE, sign_ext: 1'b0};
      OPC_LD_H_U: ctl_o = '{is_load: 1'b1, is_store: 1'b0, size: SZ_HALF, sign_ext: 1'b0};
      OPC_ST_B:   ctl_o = '{is_load: 1'b0, is_store: 1'b1, size: SZ_BYTE, sign_ext: 1'b0};
      OPC_ST_H:   ctl_o = '{is_load: 1'b0, is_store: 1'b1, size: SZ_HALF, sign_ext: 1'b0};
      OPC_ST_W:   ctl_o = '{is_load: 1'b0, is_store: 1'b1, size: SZ_WORD, sign_ext: 1'b0};
      default:    ctl_o = '{is_load: 1'b0, is_store: 1'b0, size: SZ_BYTE, sign_ext: 1'b0};
    endcase
  end

endmodule

// File: rtl/lsu_agu.sv
module lsu_agu #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  disp_i,
  output logic [ADDR_W-1:0] ea_o
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp_i[IMM_W-1]}}, disp_i};
    ea_o     = base_i + disp_ext;
  end

endmodule

// File: rtl/lsu_req_path.sv
module lsu_req_path
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  req_valid_i,
  input  acc_ctl_t              ctl_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [DATA_W-1:0]     rt_i,
  output logic [DATA_W/8-1:0]   be_o,
  output logic [DATA_W-1:0]     wdata_o,
  output logic                  rd_o,
  output logic                  misalign_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic is_mem;
  logic bad_align;
  logic go;

  always_comb begin
    is_mem    = req_valid_i && (ctl_i.is_load || ctl_i.is_store);
    unique case (ctl_i.size)
      SZ_HALF: bad_align = off_i[0];
      SZ_WORD: bad_align = |off_i;
      default: bad_align = 1'b0;
    endcase
    misalign_o = is_mem && bad_align;
    go         = is_mem && !bad_align;
    rd_o       = go && ctl_i.is_load;
  end

  // Lane k (big-endian) occupies bits DATA_W-1-8k down to DATA_W-8-8k.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit;
    always_comb begin
      unique case (ctl_i.size)
        SZ_BYTE: hit = (off_i == OFF_W'(k));
        SZ_HALF: hit = (off_i[OFF_W-1:1] == (OFF_W-1)'(k / 2));
        default: hit = 1'b1;
      endcase
      be_o[LANES-1-k] = go && ctl_i.is_store && hit;
    end

    always_comb begin
      unique case (ctl_i.size)
        SZ_BYTE: wdata_o[DATA_W-1-8*k -: 8] = rt_i[7:0];
        SZ_HALF: wdata_o[DATA_W-1-8*k -: 8] = ((k % 2) == 0) ? rt_i[15:8] : rt_i[7:0];
        default: wdata_o[DATA_W-1-8*k -: 8] = rt_i[DATA_W-1-8*k -: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_i,
  input  acc_ctl_t                    ctl_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [DATA_W-1:0]           rdata_i,
  output logic [DATA_W-1:0]           load_data_o,
  output logic                        load_valid_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic             pend_q, pend_d;
  acc_size_e        size_q, size_d;
  logic             sx_q, sx_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             cap_en;

  always_comb begin
    cap_en = rd_i;
    pend_d = rd_i;
    size_d = ctl_i.size;
    sx_d   = ctl_i.sign_ext;
    off_d  = off_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      size_q <= size_d;
      sx_q   <= sx_d;
      off_q  <= off_d;
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = rdata_i[DATA_W-1-8*off_q -: 8];
    sel_h = rdata_i[DATA_W-1-16*off_q[OFF_W-1:1] -: 16];
    unique case (size_q)
      SZ_BYTE: load_data_o = sx_q ? {{(DATA_W-8){sel_b[7]}}, sel_b}
                                  : {{(DATA_W-8){1'b0}}, sel_b};
      SZ_HALF: load_data_o = sx_q ? {{(DATA_W-16){sel_h[15]}}, sel_h}
                                  : {{(DATA_W-16){1'b0}}, sel_h};
      default: load_data_o = rdata_i;
    endcase
    load_valid_o = pend_q;
  end

  // R5: an unsigned narrow load never carries set bits above its field
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid_o && !sx_q && size_q == SZ_BYTE) |-> (load_data_o[DATA_W-1:8] == '0));

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic [DATA_W-1:0]   rs_i,
  input  logic [DATA_W-1:0]   rt_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [DATA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic                mem_rd_o,
  output logic [DATA_W-1:0]   load_data_o,
  output logic                load_valid_o,
  output logic                misalign_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  acc_ctl_t         ctl;
  logic [OFF_W-1:0] off;

  lsu_decode u_dec (
    .opcode_i (opcode_i),
    .ctl_o    (ctl)
  );

  lsu_agu #(.ADDR_W(DATA_W), .IMM_W(IMM_W)) u_agu (
    .base_i (rs_i),
    .disp_i (imm_i),
    .ea_o   (mem_addr_o)
  );

  assign off = mem_addr_o[OFF_W-1:0];

  lsu_req_path #(.DATA_W(DATA_W)) u_req (
    .req_valid_i (req_valid_i),
    .ctl_i       (ctl),
    .off_i       (off),
    .rt_i        (rt_i),
    .be_o        (mem_be_o),
    .wdata_o     (mem_wdata_o),
    .rd_o        (mem_rd_o),
    .misalign_o  (misalign_o)
  );

  lsu_load_path #(.DATA_W(DATA_W)) u_ld (
    .clk          (clk),
    .rst_n        (rst_s2_q),
    .rd_i         (mem_rd_o),
    .ctl_i        (ctl),
    .off_i        (off),
    .rdata_i      (mem_rdata_i),
    .load_data_o  (load_data_o),
    .load_valid_o (load_valid_o)
  );

  // R2: enable patterns are one lane, one aligned pair or the full word
  a_r2_be_shape: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (mem_be_o != '0) |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b1100 ||
                          mem_be_o == 4'b0011 || mem_be_o == 4'b1111));

  // R6: a misaligned request leaves memory untouched
  a_r6_no_access: assert property (@(posedge clk) disable iff (!rst_s2_q)
    misalign_o |-> (mem_be_o == '0 && !mem_rd_o));

  // R7: each strobe yields a result in the next cycle
  a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_s2_q)
    mem_rd_o |=> load_valid_o);

  // R7: no result without a preceding strobe
  a_r7_result_cause: assert property (@(posedge clk) disable iff (!rst_s2_q)
    load_valid_o |-> $past(mem_rd_o));

  // R8: an idle request drives nothing at memory
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !req_valid_i |-> (mem_be_o == '0 && !mem_rd_o && !misalign_o));

endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  opcode;
  logic [31:0] rs, rt;
  logic [15:0] imm;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [3:0]  mem_be;
  logic        mem_rd, load_valid, misalign;

  int n_chk = 0;
  int n_bad = 0;

  lsu_lane_align u0 (
    .clk (clk), .rst_n (rst_n), .req_valid_i (req_valid), .opcode_i (opcode),
    .rs_i (rs), .rt_i (rt), .imm_i (imm), .mem_rdata_i (mem_rdata),
    .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata), .mem_be_o (mem_be),
    .mem_rd_o (mem_rd), .load_data_o (load_data), .load_valid_o (load_valid),
    .misalign_o (misalign)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory model driven by the design, and a shadow updated from expectations.
  logic [31:0] mem  [0:15];
  logic [31:0] refm [0:15];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[5:2]];
    for (int k = 0; k < 4; k++)
      if (mem_be[k]) mem[mem_addr[5:2]][8*k+7 -: 8] <= mem_wdata[8*k+7 -: 8];
  end

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t sb_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_load(input logic [5:0] op, input logic [31:0] w,
                                           input logic [1:0] off);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[31-8*off -: 8];
    h = off[1] ? w[15:0] : w[31:16];
    case (op)
      6'h20:   return {{24{b[7]}}, b};
      6'h24:   return {24'h0, b};
      6'h21:   return {{16{h[15]}}, h};
      6'h25:   return {16'h0, h};
      default: return w;
    endcase
  endfunction

  // Driver: present one request, check the request-cycle outputs, push loads.
  task automatic issue(input logic [5:0] op, input logic [31:0] rsv, input logic [31:0] rtv,
                       input logic [15:0] immv);
    logic [31:0] ea;
    logic [1:0]  off;
    logic        ld, st, mis;
    int          sz;
    logic [3:0]  be;
    logic [31:0] wd;
    ea  = rsv + {{16{immv[15]}}, immv};
    off = ea[1:0];
    ld  = (op == 6'h20 || op == 6'h21 || op == 6'h23 || op == 6'h24 || op == 6'h25);
    st  = (op == 6'h28 || op == 6'h29 || op == 6'h2b);
    sz  = (op == 6'h20 || op == 6'h24 || op == 6'h28) ? 0 :
          (op == 6'h21 || op == 6'h25 || op == 6'h29) ? 1 : 2;
    mis = (ld || st) && ((sz == 1 && off[0]) || (sz == 2 && off != 2'b00));
    be  = 4'b0000;
    wd  = rtv;
    if (st && !mis) begin
      if (sz == 0) begin be = 4'b1000 >> off; wd = {4{rtv[7:0]}}; end
      else if (sz == 1) begin be = off[1] ? 4'b0011 : 4'b1100; wd = {2{rtv[15:0]}}; end
      else be = 4'b1111;
    end
    @(negedge clk);
    req_valid = 1'b1; opcode = op; rs = rsv; rt = rtv; imm = immv;
    #1;
    check("R1 address", mem_addr, ea);
    check("R6/R8 misalign flag", {31'b0, misalign}, {31'b0, mis});
    check("R2/R6 byte enables", {28'b0, mem_be}, {28'b0, be});
    check("R7/R8 read strobe", {31'b0, mem_rd}, {31'b0, ld && !mis});
    if (st && !mis) begin
      check("R3 write data", mem_wdata, wd);
      for (int k = 0; k < 4; k++)
        if (be[k]) refm[ea[5:2]][8*k+7 -: 8] = wd[8*k+7 -: 8];
    end
    if (ld && !mis) begin
      exp_t e;
      e.val = exp_load(op, refm[ea[5:2]], off);
      e.req = "R4/R5 load data";
      sb_q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: every load result must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && load_valid) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6/R7 unexpected load_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, load_data, e.val);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 32'h80F1_7F02 ^ (i * 32'h0107_0B13);
      refm[i] = 32'h80F1_7F02 ^ (i * 32'h0107_0B13);
    end
    mem_rdata = '0;
    req_valid = 1'b0; opcode = '0; rs = '0; rt = '0; imm = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 load_valid after reset", {31'b0, load_valid}, 32'd0);
    check("R8 idle enables", {28'b0, mem_be}, 32'd0);
    check("R8 idle strobe", {31'b0, mem_rd}, 32'd0);

    // R1: address forms
    issue(6'h23, 32'h0000_0000, 32'h0, 16'h0010);
    issue(6'h23, 32'h0000_0024, 32'h0, 16'h0000);
    issue(6'h23, 32'h0000_0020, 32'h0, 16'hFFFC);
    issue(6'h23, 32'h7FFF_FFF0, 32'h0, 16'h8000);
    idle(2);

    // R4/R5: every signed and unsigned load at every legal offset
    for (int o = 0; o < 4; o++) begin
      issue(6'h20, 32'h0000_0010, 32'h0, 16'(o));
      issue(6'h24, 32'h0000_0010, 32'h0, 16'(o));
    end
    for (int o = 0; o < 4; o += 2) begin
      issue(6'h21, 32'h0000_0014, 32'h0, 16'(o));
      issue(6'h25, 32'h0000_0014, 32'h0, 16'(o));
    end
    idle(2);

    // R2/R3: stores of each size, then read back through loads
    for (int o = 0; o < 4; o++) issue(6'h28, 32'h0000_0030, 32'h1234_56A0 + o, 16'(o));
    issue(6'h23, 32'h0000_0030, 32'h0, 16'h0000);
    issue(6'h29, 32'h0000_0034, 32'hDEAD_8001, 16'h0000);
    issue(6'h29, 32'h0000_0034, 32'hBEEF_7FFE, 16'h0002);
    issue(6'h21, 32'h0000_0034, 32'h0, 16'h0000);
    issue(6'h25, 32'h0000_0034, 32'h0, 16'h0000);
    issue(6'h2b, 32'h0000_0038, 32'hCAFE_F00D, 16'h0000);
    issue(6'h23, 32'h0000_0038, 32'h0, 16'h0000);
    issue(6'h20, 32'h0000_0038, 32'h0, 16'h0000);
    idle(2);

    // R6: misaligned halfword and word accesses do nothing
    issue(6'h21, 32'h0000_0011, 32'h0, 16'h0000);
    issue(6'h29, 32'h0000_003C, 32'hFFFF_FFFF, 16'h0003);
    issue(6'h23, 32'h0000_0012, 32'h0, 16'h0000);
    issue(6'h2b, 32'h0000_003C, 32'hFFFF_FFFF, 16'h0001);
    issue(6'h23, 32'h0000_003C, 32'h0, 16'h0000);
    idle(2);

    // R8: opcodes outside the set
    issue(6'h00, 32'h0000_0010, 32'h0, 16'h0000);
    issue(6'h22, 32'h0000_0010, 32'hFFFF_FFFF, 16'h0000);
    issue(6'h2a, 32'h0000_003C, 32'hFFFF_FFFF, 16'h0000);
    issue(6'h23, 32'h0000_003C, 32'h0, 16'h0000);
    idle(3);

    n_chk++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7 missing load results: actual %0d expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule